// File: doc/BRIEF.md
# Three-Byte Message Framer

This block watches a byte stream that arrives one byte per clock and recovers message boundaries from it. A message is a fixed group of three bytes, and the only framing hint is a single marker bit in the leading byte. While the block has no message in progress, it throws away every byte whose marker bit is clear. The first byte that has the marker set is taken as the start of a message. The two bytes that follow are then accepted unconditionally.

Once the final byte of a message has been taken, the block raises a one-cycle completion pulse and presents the whole message as one 24-bit word. The byte that arrives during that completion cycle is already examined as a possible new leading byte. Messages can therefore follow each other with no gap. A synchronous reset abandons any partial message and returns the block to searching.

Top module: `pkt3_framer`

## Requirements
- R1: While searching, a byte whose bit 3 (the marker, mask 0x08) is 0 is discarded and produces no completion pulse.
- R2: A byte with bit 3 set, seen while searching, becomes byte 1 of a message. The next two bytes are accepted as bytes 2 and 3 whatever their bit 3 holds, and none of them restarts the message.
- R3: `msg_done` is high for exactly one cycle: the cycle right after the clock edge that samples byte 3.
- R4: While `msg_done` is high, `msg_word[23:16]` holds byte 1, `[15:8]` holds byte 2 and `[7:0]` holds byte 3.
- R5: A byte with bit 3 set that arrives during the `msg_done` cycle starts the next message, so messages can run back to back.
- R6: A byte with bit 3 clear that arrives during the `msg_done` cycle is discarded, and searching resumes.
- R7: `rst` is active high and synchronous. It puts the block in the search state with `msg_done` low and discards any partial message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| byte_in | input | 8 | Incoming byte, one per clock |
| msg_done | output | 1 | One-cycle pulse: a full message has been taken |
| msg_word | output | 24 | Assembled message, valid while msg_done is high |

## Verification
The framer is driven with leading junk bytes that have the marker clear, which shows that discarding works and that no pulse appears early. Messages whose second and third bytes have the marker clear, or set, show that only the first byte is examined. A stream with no gap, where the byte in the completion cycle carries the marker, separates correct back-to-back handling from a design that wastes a cycle. The opposite case, a marker-clear byte in that cycle, shows that such a byte is dropped. A reset asserted partway through a message, followed by a fresh message, shows that no stale bytes or pulses survive the reset.

// File: rtl/pkt3_pkg.sv
package pkt3_pkg;

    // Phase of the boundary tracker
    typedef enum logic [1:0] {
        PH_SEEK = 2'd0,   // looking for a byte with the marker set
        PH_FILL = 2'd1,   // collecting the remaining bytes of a message
        PH_FIN  = 2'd2    // message complete; also searches like PH_SEEK
    } phase_e;

endpackage

// File: rtl/pkt3_seq.sv
module pkt3_seq
    import pkt3_pkg::*;
#(
    parameter int MSG_BYTES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic mark,
    output logic done
);

    localparam int CNT_W = $clog2(MSG_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MSG_BYTES - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] taken;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_FILL: begin
                st_d.taken = st_q.taken + 1'b1;
                if (st_q.taken == LAST_IDX) begin
                    st_d.phase = PH_FIN;
                end
            end
            default: begin
                // PH_SEEK and PH_FIN share the same start-detection rule
                if (mark) begin
                    st_d.phase = PH_FILL;
                    st_d.taken = CNT_W'(1);
                end else begin
                    st_d.phase = PH_SEEK;
                    st_d.taken = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= PH_SEEK;
            st_q.taken <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done = (st_q.phase == PH_FIN);

    // R1
    seek_discard_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_SEEK && !mark) |=> (st_q.phase == PH_SEEK && !done));

    // R2
    fill_no_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_FILL) |=> (st_q.phase != PH_SEEK));

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    done_after_fill_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(st_q.phase) == PH_FILL));

    // R5
    back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        (done && mark) |=> (st_q.phase == PH_FILL));

    // R6
    done_discard_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !mark) |=> (st_q.phase == PH_SEEK));

    // R7
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!done && st_q.phase == PH_SEEK));

endmodule

// File: rtl/pkt3_shift.sv
module pkt3_shift #(
    parameter int BYTE_W    = 8,
    parameter int MSG_BYTES = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [BYTE_W-1:0]           din,
    output logic [BYTE_W*MSG_BYTES-1:0] word
);

    localparam int WORD_W = BYTE_W * MSG_BYTES;

    typedef struct packed {
        logic [WORD_W-1:0] bytes;
    } shift_t;

    shift_t sh_d, sh_q;

    // Oldest byte ends up in the top lane, newest in the bottom lane
    always_comb begin
        sh_d = sh_q;
        sh_d.bytes = {sh_q.bytes[WORD_W-BYTE_W-1:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q.bytes <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign word = sh_q.bytes;

    // R4
    newest_lane_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (word[BYTE_W-1:0] == $past(din)));

    // R4
    lane_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (word[2*BYTE_W-1:BYTE_W] == $past(word[BYTE_W-1:0])));

endmodule

// File: rtl/pkt3_framer.sv
module pkt3_framer #(
    parameter int BYTE_W    = 8,
    parameter int MSG_BYTES = 3,
    parameter int MARK_BIT  = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [BYTE_W-1:0]           byte_in,
    output logic                        msg_done,
    output logic [BYTE_W*MSG_BYTES-1:0] msg_word
);

    logic start_mark;

    assign start_mark = byte_in[MARK_BIT];

    pkt3_seq #(
        .MSG_BYTES (MSG_BYTES)
    ) seq_i (
        .clk  (clk),
        .rst  (rst),
        .mark (start_mark),
        .done (msg_done)
    );

    pkt3_shift #(
        .BYTE_W    (BYTE_W),
        .MSG_BYTES (MSG_BYTES)
    ) shift_i (
        .clk  (clk),
        .rst  (rst),
        .din  (byte_in),
        .word (msg_word)
    );

endmodule

// File: tb/pkt3_framer_tb.sv
module pkt3_framer_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  byte_in = 8'h00;
    logic        msg_done;
    logic [23:0] msg_word;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt3_framer dut_i (
        .clk      (clk),
        .rst      (rst),
        .byte_in  (byte_in),
        .msg_done (msg_done),
        .msg_word (msg_word)
    );

    // At a falling edge, check the outputs that result from earlier bytes,
    // then present the next byte.
    task automatic step(input logic [7:0] b, input bit exp_done,
                        input logic [23:0] exp_word, input string req);
        @(negedge clk);
        n_checks++;
        if (msg_done !== exp_done) begin
            n_errors++;
            $display("FAIL %s: msg_done=%0b expected %0b", req, msg_done, exp_done);
        end
        if (exp_done) begin
            n_checks++;
            if (msg_word !== exp_word) begin
                n_errors++;
                $display("FAIL %s: msg_word=%06h expected %06h", req, msg_word, exp_word);
            end
        end
        byte_in = b;
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        byte_in = 8'h08;
        repeat (2) @(negedge clk);
        n_checks++;
        if (msg_done !== 1'b0) begin
            n_errors++;
            $display("FAIL R7: msg_done=%0b expected 0 in reset", msg_done);
        end
        rst = 1'b0;
        byte_in = 8'h00;
    endtask

    task automatic t_junk_then_msg();
        // R1: junk bytes with bit 3 clear give no pulse
        step(8'h17, 1'b0, 24'h0, "R1");
        step(8'h40, 1'b0, 24'h0, "R1");
        step(8'h00, 1'b0, 24'h0, "R1");
        // R2: start byte, then bytes 2 and 3 with bit 3 clear
        step(8'h18, 1'b0, 24'h0, "R1");
        step(8'h00, 1'b0, 24'h0, "R2");
        step(8'h07, 1'b0, 24'h0, "R2");
        // R3/R4: pulse one cycle after byte 3; R6: this byte is dropped
        step(8'h21, 1'b1, 24'h180007, "R3");
        step(8'h00, 1'b0, 24'h0, "R3");
        step(8'h00, 1'b0, 24'h0, "R6");
        step(8'h00, 1'b0, 24'h0, "R6");
    endtask

    task automatic t_marked_body();
        // R2: bytes 2 and 3 carry the marker but do not restart the message
        step(8'h0F, 1'b0, 24'h0, "R2");
        step(8'h08, 1'b0, 24'h0, "R2");
        step(8'h0C, 1'b0, 24'h0, "R2");
        step(8'h00, 1'b1, 24'h0F080C, "R4");
        step(8'h00, 1'b0, 24'h0, "R3");
    endtask

    task automatic t_back_to_back();
        step(8'h08, 1'b0, 24'h0, "R5");
        step(8'hFF, 1'b0, 24'h0, "R5");
        step(8'hAA, 1'b0, 24'h0, "R5");
        // R5: the marked byte in the done cycle opens the next message
        step(8'h3C, 1'b1, 24'h08FFAA, "R5");
        step(8'h11, 1'b0, 24'h0, "R5");
        step(8'h22, 1'b0, 24'h0, "R5");
        // R6: this byte has bit 3 clear and is discarded
        step(8'h05, 1'b1, 24'h3C1122, "R5");
        step(8'h26, 1'b0, 24'h0, "R6");
        step(8'h31, 1'b0, 24'h0, "R6");
        step(8'h00, 1'b0, 24'h0, "R6");
        step(8'h00, 1'b0, 24'h0, "R6");
    endtask

    task automatic t_reset_mid_msg();
        step(8'h09, 1'b0, 24'h0, "R7");
        step(8'h55, 1'b0, 24'h0, "R7");
        @(negedge clk);
        rst = 1'b1;
        byte_in = 8'h0F;
        @(negedge clk);
        n_checks++;
        if (msg_done !== 1'b0) begin
            n_errors++;
            $display("FAIL R7: msg_done=%0b expected 0 after reset", msg_done);
        end
        rst = 1'b0;
        byte_in = 8'h77;
        // R7: the partial message is gone; the byte after reset is not byte 3
        step(8'h66, 1'b0, 24'h0, "R7");
        step(8'h88, 1'b0, 24'h0, "R7");
        step(8'h01, 1'b0, 24'h0, "R7");
        step(8'h02, 1'b0, 24'h0, "R7");
        step(8'h00, 1'b1, 24'h880102, "R7");
        step(8'h00, 1'b0, 24'h0, "R3");
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        t_reset_state();
        t_junk_then_msg();
        t_marked_body();
        t_back_to_back();
        t_reset_mid_msg();
        finished = 1'b1;
        report();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, actual timeout expected finish");
            report();
            $finish;
        end
    end

endmodule